// File: doc/BRIEF.md
# Multi-Sector Erase Collection Window

This block is part of a flash command interpreter. It starts working once the interpreter has decoded a complete sector-erase sequence. From that first command onward it keeps a bitmap of the sectors to erase. It also runs a countdown measured in clock cycles. Each new sector-erase command that arrives before the countdown runs out is added to the bitmap and restarts the countdown. Sectors can arrive in any order. The set can grow from a single sector up to every sector.

The window closes when the countdown expires with no new command. At that point the block emits a one-cycle start pulse toward the erase engine. The finished bitmap is then held unchanged until the engine acknowledges it. An abort, or a reset, discards the bitmap and closes the window without any start pulse. The command pulse arrives already decoded with a sector index, so this block contains no unlock decoding and no erase sequencing.

Top module: `sector_erase_accum`

## Requirements
- R1: While reset is asserted, and directly after it, `sector_mask` is all zero and both `window_open` and `erase_start` are low.
- R2: When the window is idle, a valid command (`cmd_valid` high, `cmd_sector` below `NUM_SECTORS`, `abort` low) opens the window. `window_open` is high in the next cycle and `sector_mask` bit `cmd_sector` is set in that cycle.
- R3: While the window is open, each valid command ORs bit `cmd_sector` into `sector_mask`. Bit i of the mask stands for sector i, and the order of arrival makes no difference.
- R4: A command for a sector that is already in the mask leaves the mask unchanged but still restarts the countdown.
- R5: After the last accepted command, `window_open` stays high for exactly `TIMEOUT_CYC` cycles. In the cycle where it falls, `erase_start` is high.
- R6: `erase_start` is high for one cycle only. From then on, `sector_mask` holds its value until `ack` is high for a cycle. The cycle after that, the mask reads zero.
- R7: Commands that arrive after the window has closed and before `ack` have no effect. The mask does not change and the window stays closed.
- R8: `abort` clears the mask and closes the window in the next cycle, and no `erase_start` follows. When `abort` and a command occur in the same cycle, `abort` wins.
- R9: A command that arrives in the final cycle of the window restarts the countdown instead of letting the window expire.
- R10: A command whose `cmd_sector` is `NUM_SECTORS` or higher is ignored. It neither opens the window, adds a bit, nor restarts the countdown.
- R11: Every sector can be collected in a single window, so the mask can become all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | One-cycle pulse: a decoded sector-erase command |
| cmd_sector | input | $clog2(NUM_SECTORS) | Sector index carried by the command |
| abort | input | 1 | Discard the collected set and close the window |
| ack | input | 1 | The erase engine has taken the held mask |
| sector_mask | output | NUM_SECTORS | Collected sectors, bit i = sector i |
| window_open | output | 1 | The collection window is open |
| erase_start | output | 1 | One-cycle pulse when the window expires |

## Verification
Two pairs of events can fall in the same cycle. First, a new command can arrive in the same cycle the countdown reaches its last tick. Second, an abort can coincide with either a command or that last tick. The bench lets the countdown run down to its final cycle and places the command, or the abort, exactly there. It then counts the following cycles. A restarted window must stay open for a full `TIMEOUT_CYC` cycles before its start pulse. An abort must leave the mask at zero with no start pulse at all.

// File: rtl/sea_pkg.sv
package sea_pkg;

  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_OPEN = 2'd1,
    WIN_HOLD = 2'd2
  } win_state_e;

  // true when a sector index addresses an existing sector
  function automatic logic idx_in_range(input logic [31:0] idx,
                                        input logic [31:0] count);
    return idx < count;
  endfunction

  // next countdown value: reload wins, otherwise step down to zero
  function automatic logic [31:0] countdown_next(input logic [31:0] cur,
                                                 input logic        reload,
                                                 input logic        running,
                                                 input logic [31:0] period);
    if (reload)                    return period;
    else if (running && cur != 0)  return cur - 32'd1;
    else                           return cur;
  endfunction

endpackage

// File: rtl/sea_sector_set.sv
module sea_sector_set #(
  parameter int NUM_SECTORS = 16,
  localparam int IDX_W = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   add,
  input  logic                   clear,
  input  logic [IDX_W-1:0]       idx,
  output logic [NUM_SECTORS-1:0] sel,
  output logic [NUM_SECTORS-1:0] mask
);

  // one-hot decode of the incoming index, one compare per sector
  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_dec
    assign sel[g] = (32'(idx) == g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask <= '0;
    else if (clear)  mask <= '0;
    else if (add)    mask <= mask | sel;
  end

endmodule

// File: rtl/sea_window_timer.sv
module sea_window_timer #(
  parameter int TIMEOUT_CYC = 5000,
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  input  logic flush,
  output logic last_tick
);

  logic [CNT_W-1:0] cnt;
  logic [31:0]      nxt;

  assign nxt = sea_pkg::countdown_next(32'(cnt), load, run, 32'(TIMEOUT_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (flush)  cnt <= '0;
    else             cnt <= nxt[CNT_W-1:0];
  end

  assign last_tick = (cnt == CNT_W'(1));

endmodule

// File: rtl/sea_window_ctrl.sv
module sea_window_ctrl (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_hit,
  input  logic                 abort,
  input  logic                 ack,
  input  logic                 last_tick,
  output sea_pkg::win_state_e  state,
  output logic                 accept,
  output logic                 expire,
  output logic                 clear,
  output logic                 start_q
);
  import sea_pkg::*;

  win_state_e state_nxt;

  assign accept = cmd_hit && !abort && (state != WIN_HOLD);
  assign expire = (state == WIN_OPEN) && last_tick && !accept && !abort;
  assign clear  = abort || ((state == WIN_HOLD) && ack);

  always_comb begin
    state_nxt = state;
    unique case (state)
      WIN_IDLE: if (accept) state_nxt = WIN_OPEN;
      WIN_OPEN: begin
        if (abort)       state_nxt = WIN_IDLE;
        else if (expire) state_nxt = WIN_HOLD;
      end
      WIN_HOLD: if (clear) state_nxt = WIN_IDLE;
      default:  state_nxt = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= WIN_IDLE;
      start_q <= 1'b0;
    end else begin
      state   <= state_nxt;
      start_q <= expire;
    end
  end

endmodule

// File: rtl/sector_erase_accum.sv
module sector_erase_accum #(
  parameter int NUM_SECTORS = 16,
  parameter int TIMEOUT_CYC = 5000,
  localparam int IDX_W = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [IDX_W-1:0]       cmd_sector,
  input  logic                   abort,
  input  logic                   ack,
  output logic [NUM_SECTORS-1:0] sector_mask,
  output logic                   window_open,
  output logic                   erase_start
);
  import sea_pkg::*;

  // named internal events, visible to the bound checker
  logic                   idx_ok;
  logic                   cmd_hit;
  logic                   accept;
  logic                   expire;
  logic                   clear;
  logic                   last_tick;
  logic                   in_hold;
  logic [NUM_SECTORS-1:0] sel_bit;
  win_state_e             state;

  assign idx_ok  = idx_in_range(32'(cmd_sector), 32'(NUM_SECTORS));
  assign cmd_hit = cmd_valid && idx_ok;

  sea_window_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_hit   (cmd_hit),
    .abort     (abort),
    .ack       (ack),
    .last_tick (last_tick),
    .state     (state),
    .accept    (accept),
    .expire    (expire),
    .clear     (clear),
    .start_q   (erase_start)
  );

  sea_window_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .run       (state == WIN_OPEN),
    .flush     (abort),
    .last_tick (last_tick)
  );

  sea_sector_set #(.NUM_SECTORS(NUM_SECTORS)) u_set (
    .clk   (clk),
    .rst_n (rst_n),
    .add   (accept),
    .clear (clear),
    .idx   (cmd_sector),
    .sel   (sel_bit),
    .mask  (sector_mask)
  );

  assign window_open = (state == WIN_OPEN);
  assign in_hold     = (state == WIN_HOLD);

endmodule

// File: rtl/sea_checker.sv
module sea_checker #(
  parameter int NUM_SECTORS = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic                   abort,
  input logic                   ack,
  input logic                   accept,
  input logic                   in_hold,
  input logic [NUM_SECTORS-1:0] sel_bit,
  input logic [NUM_SECTORS-1:0] sector_mask,
  input logic                   window_open,
  input logic                   erase_start
);

  p_open_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> window_open);

  p_bit_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((sector_mask & $past(sel_bit)) == $past(sel_bit)));

  p_start_on_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (!window_open && $past(window_open)));

  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && !ack && !abort) |=> $stable(sector_mask));

  p_hold_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && cmd_valid && !ack && !abort) |=> !window_open);

  p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (sector_mask == '0 && !window_open && !erase_start));

endmodule

bind sector_erase_accum sea_checker #(.NUM_SECTORS(NUM_SECTORS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .abort       (abort),
  .ack         (ack),
  .accept      (accept),
  .in_hold     (in_hold),
  .sel_bit     (sel_bit),
  .sector_mask (sector_mask),
  .window_open (window_open),
  .erase_start (erase_start)
);

// File: tb/sector_erase_accum_bench.sv
module sector_erase_accum_bench;

  localparam int NS  = 11;
  localparam int TMO = 4;
  localparam int IW  = $clog2(NS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [IW-1:0] cmd_sector = '0;
  logic          abort = 1'b0;
  logic          ack = 1'b0;
  logic [NS-1:0] sector_mask;
  logic          window_open;
  logic          erase_start;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sector_erase_accum #(.NUM_SECTORS(NS), .TIMEOUT_CYC(TMO)) u_sector_erase_accum (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sector(cmd_sector),
    .abort(abort), .ack(ack), .sector_mask(sector_mask),
    .window_open(window_open), .erase_start(erase_start)
  );

  // row: cmd, idx[3:0], abort, ack, exp_mask[10:0], exp_open, exp_start
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 4'd3,  1'b0, 1'b0, 11'h008, 1'b1, 1'b0},  // R2 open
    {1'b0, 4'd0,  1'b0, 1'b0, 11'h008, 1'b1, 1'b0},
    {1'b1, 4'd0,  1'b0, 1'b0, 11'h009, 1'b1, 1'b0},  // R3 lower index after higher
    {1'b1, 4'd3,  1'b0, 1'b0, 11'h009, 1'b1, 1'b0},  // R4 duplicate, reload
    {1'b0, 4'd0,  1'b0, 1'b0, 11'h009, 1'b1, 1'b0},
    {1'b0, 4'd0,  1'b0, 1'b0, 11'h009, 1'b1, 1'b0},
    {1'b0, 4'd0,  1'b0, 1'b0, 11'h009, 1'b1, 1'b0},
    {1'b0, 4'd0,  1'b0, 1'b0, 11'h009, 1'b0, 1'b1},  // R5 expiry
    {1'b1, 4'd5,  1'b0, 1'b0, 11'h009, 1'b0, 1'b0},  // R7 ignored while held
    {1'b0, 4'd0,  1'b0, 1'b0, 11'h009, 1'b0, 1'b0},  // R6 held
    {1'b0, 4'd0,  1'b0, 1'b1, 11'h000, 1'b0, 1'b0},  // R6 ack clears
    {1'b1, 4'd12, 1'b0, 1'b0, 11'h000, 1'b0, 1'b0},  // R10 out of range
    {1'b1, 4'd10, 1'b0, 1'b0, 11'h400, 1'b1, 1'b0},  // R2 top sector
    {1'b1, 4'd2,  1'b1, 1'b0, 11'h000, 1'b0, 1'b0}   // R8 abort beats cmd
  };

  task automatic cyc(input logic c, input logic [IW-1:0] i, input logic a, input logic k);
    @(negedge clk);
    cmd_valid = c; cmd_sector = i; abort = a; ack = k;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [NS-1:0] m, input logic o, input logic s);
    checks++;
    if (sector_mask !== m || window_open !== o || erase_start !== s) begin
      errors++;
      $display("FAIL %s: mask=%h open=%b start=%b expected mask=%h open=%b start=%b",
               req, sector_mask, window_open, erase_start, m, o, s);
    end
  endtask

  // after an accepted command: TMO-1 open cycles, then the start cycle
  task automatic run_out(input string req, input logic [NS-1:0] m);
    for (int k = 1; k <= TMO; k++) begin
      cyc(1'b0, '0, 1'b0, 1'b0);
      if (k < TMO) chk(req, m, 1'b1, 1'b0);
      else         chk(req, m, 1'b0, 1'b1);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NS-1:0] exp_m;
    #23;
    chk("R1 in reset", '0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after reset", '0, 1'b0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      cyc(VEC[v][19], VEC[v][18:15], VEC[v][14], VEC[v][13]);
      chk($sformatf("table row %0d (R2..R10)", v), VEC[v][12:2], VEC[v][1], VEC[v][0]);
    end

    // R5 exact window length after a single command
    cyc(1'b1, 4'd1, 1'b0, 1'b0);
    chk("R5 open", 11'h002, 1'b1, 1'b0);
    run_out("R5 window length", 11'h002);
    cyc(1'b0, '0, 1'b0, 1'b0);
    chk("R6 start is one cycle", 11'h002, 1'b0, 1'b0);
    cyc(1'b0, '0, 1'b0, 1'b1);
    chk("R6 ack", '0, 1'b0, 1'b0);

    // R9 command on the last window cycle restarts the countdown
    cyc(1'b1, 4'd7, 1'b0, 1'b0);
    for (int k = 1; k < TMO; k++) cyc(1'b0, '0, 1'b0, 1'b0);
    chk("R9 last cycle open", 11'h080, 1'b1, 1'b0);
    cyc(1'b1, 4'd4, 1'b0, 1'b0);
    chk("R9 late command accepted", 11'h090, 1'b1, 1'b0);
    run_out("R9 restarted window", 11'h090);
    cyc(1'b0, '0, 1'b0, 1'b1);
    chk("R6 ack after R9", '0, 1'b0, 1'b0);

    // R8 abort on the expiry cycle: no start
    cyc(1'b1, 4'd6, 1'b0, 1'b0);
    for (int k = 1; k < TMO; k++) cyc(1'b0, '0, 1'b0, 1'b0);
    cyc(1'b0, '0, 1'b1, 1'b0);
    chk("R8 abort at expiry", '0, 1'b0, 1'b0);
    cyc(1'b0, '0, 1'b0, 1'b0);
    chk("R8 no start later", '0, 1'b0, 1'b0);

    // R11 every sector, descending order
    exp_m = '0;
    for (int s = NS - 1; s >= 0; s--) begin
      cyc(1'b1, IW'(s), 1'b0, 1'b0);
      exp_m[s] = 1'b1;
    end
    chk("R11 all sectors", exp_m, 1'b1, 1'b0);
    run_out("R11 all sectors start", exp_m);

    // R1 reset while holding
    @(negedge clk); rst_n = 1'b0;
    #2;
    chk("R1 reset while held", '0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b0, '0, 1'b0, 1'b0);
    chk("R1 idle after reset", '0, 1'b0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule